// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Peripheral

This block hangs off a simple processor bus and gives software three 8-bit parallel ports, named A, B and C. A bus access is qualified by a chip select and steered by a 2-bit offset to one of the three ports or to a control register. Through that register software sets whether each port, or each half of port C, is an input or an output. It can also place ports A and B in a strobed mode, in which external handshake logic takes over some port C lines.

The control offset accepts two kinds of word. When bit 7 is set, the word reconfigures the directions and modes of all ports at once. When bit 7 is clear, the word sets or clears a single port C bit. In the strobed modes, port C also serves as a status word: a read of port C returns handshake flags, taken from hook inputs, in place of some of its lines. Every bus effect is taken on a rising clock edge. Read data comes out of a register one cycle after the read strobe is sampled.

Top module: `tri_port_pio`

## Requirements
- R1: After synchronous reset, all three ports are inputs in basic mode: `pa_oe`, `pb_oe` and `pc_oe` are 0x00, all output latches are 0x00, `rdata` is 0x00, and both interrupt enables are 0.
- R2: An access happens only when `cs` is high at the clock edge. Offset 0 selects port A, offset 1 port B, offset 2 port C and offset 3 the control register. A write or read with `cs` low changes nothing, including `rdata`.
- R3: A control write with bit 7 = 1 is a mode word. Bit 4 = 1 makes port A an input and bits 6:5 give the port A mode (any nonzero value is strobed). Bit 1 = 1 makes port B an input and bit 2 = 1 makes it strobed. Bit 3 = 1 makes port C bits 7:4 inputs, and bit 0 = 1 makes bits 3:0 inputs. An output port or nibble has all its enable bits at 1. For example, 0x90 gives `pa_oe`=0x00, `pb_oe`=0xFF and `pc_oe`=0xFF.
- R4: Every mode word clears the A, B and C output latches and both interrupt enables to 0.
- R5: A read of an input port returns the pin values sampled at the read edge, and `rdata` shows them from the next cycle on. `rdata` holds its value in any cycle without a read.
- R6: A write to an output port A or B drives that value on the pins until the next write or mode word. A write to a port configured as input is discarded, and its output latch keeps its value.
- R7: A control write with bit 7 = 0 sets port C latch bit number wdata[3:1] to wdata[0] and leaves every other latch bit and the configuration unchanged. Bit number 4 also writes the port A interrupt enable, and bit number 2 also writes the port B interrupt enable.
- R8: A port C write updates only the latch bits of the nibbles that are outputs. A port C read returns the latch for output nibbles and the pins for input nibbles.
- R9: With port A strobed, a port C read returns bit 5 = `hk_a_full`, bit 4 = the port A interrupt enable and bit 3 = their AND, and `pc_oe[5:3]` is 0. For example, 0xB0 gives `pc_oe`=0xC7.
- R10: With port B strobed, a port C read returns bit 1 = `hk_b_full`, bit 2 = the port B interrupt enable and bit 0 = their AND, and `pc_oe[2:0]` is 0.
- R11: A read of the control offset returns 0x00. A read of port A or B configured as output returns its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| addr | input | 2 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C drive enables |
| hk_a_full | input | 1 | Buffer-full flag from port A handshake logic |
| hk_b_full | input | 1 | Buffer-full flag from port B handshake logic |

## Verification
The bench aims at the corner cases where the two control formats meet. One is a set/reset word naming bit 4 or 2 while a strobed mode is active. A design that did not mirror that bit into the interrupt enable would report a stuck status bit 3 or bit 0. Another is a mode word issued after the latches have been loaded. Here a design that kept old latch values would drive stale data the moment a port turned to output. The bench also sends port C writes under mixed nibble directions, and port writes while the port is an input, which would show up as corrupted latches. Chip-select-low strobes are included too, since a design that ignored `cs` would reconfigure or overwrite `rdata`.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int PW = 8;
  localparam int AW = 2;
  localparam logic [1:0] OFS_A   = 2'd0;
  localparam logic [1:0] OFS_B   = 2'd1;
  localparam logic [1:0] OFS_C   = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  typedef struct packed {
    logic       a_in;
    logic [1:0] a_mode;
    logic       b_in;
    logic       b_mode;
    logic       chi_in;
    logic       clo_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_in: 1'b1, a_mode: 2'b00, b_in: 1'b1,
                               b_mode: 1'b0, chi_in: 1'b1, clo_in: 1'b1};

  function automatic cfg_t decode_modeword(input logic [7:0] w);
    cfg_t c;
    c.a_in   = w[4];
    c.a_mode = w[6:5];
    c.b_in   = w[1];
    c.b_mode = w[2];
    c.chi_in = w[3];
    c.clo_in = w[0];
    return c;
  endfunction
endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
#(
  parameter int PW_P = PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic            pc_we,
  input  logic [PW_P-1:0] wdata,
  output cfg_t            cfg,
  output logic [PW_P-1:0] pc_lat,
  output logic            inte_a,
  output logic            inte_b,
  output logic            clr
);
  localparam int HALF = PW_P / 2;
  logic [PW_P-1:0] wmask;

  assign clr   = ctl_we & wdata[7];
  assign wmask = {{HALF{~cfg.chi_in}}, {HALF{~cfg.clo_in}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RST;
      pc_lat <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (ctl_we) begin
      if (wdata[7]) begin
        cfg    <= decode_modeword(wdata[7:0]);
        pc_lat <= '0;
        inte_a <= 1'b0;
        inte_b <= 1'b0;
      end else begin
        pc_lat[wdata[3:1]] <= wdata[0];
        if (wdata[3:1] == 3'd4) inte_a <= wdata[0];
        if (wdata[3:1] == 3'd2) inte_b <= wdata[0];
      end
    end else if (pc_we) begin
      pc_lat <= (pc_lat & ~wmask) | (wdata & wmask);
    end
  end

  assert_modeword_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[7]) |=> (pc_lat == '0 && !inte_a && !inte_b));

  assert_bitword_keeps_cfg_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !wdata[7]) |=> $stable(cfg));

  assert_bitword_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !wdata[7]) |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1));
endmodule

// File: rtl/tp_latch.sv
module tp_latch #(
  parameter int PW_P = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            we,
  input  logic            is_in,
  input  logic [PW_P-1:0] d,
  output logic [PW_P-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)        q <= '0;
    else if (we && !is_in) q <= d;
  end

  assert_input_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (we && is_in && !clr) |=> $stable(q));
endmodule

// File: rtl/tp_rdmux.sv
module tp_rdmux
  import tp_pkg::*;
#(
  parameter int PW_P = PW,
  parameter int AW_P = AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [AW_P-1:0] sel,
  input  logic [PW_P-1:0] a_val,
  input  logic [PW_P-1:0] b_val,
  input  logic [PW_P-1:0] c_val,
  output logic [PW_P-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      unique case (sel)
        OFS_A:   rdata <= a_val;
        OFS_B:   rdata <= b_val;
        OFS_C:   rdata <= c_val;
        default: rdata <= '0;
      endcase
    end
  end

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_ctl_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == OFS_CTL) |=> (rdata == '0));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import tp_pkg::*;
#(
  parameter int PW_P = PW,
  parameter int AW_P = AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic [AW_P-1:0] addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [PW_P-1:0] wdata,
  output logic [PW_P-1:0] rdata,
  input  logic [PW_P-1:0] pa_in,
  output logic [PW_P-1:0] pa_out,
  output logic [PW_P-1:0] pa_oe,
  input  logic [PW_P-1:0] pb_in,
  output logic [PW_P-1:0] pb_out,
  output logic [PW_P-1:0] pb_oe,
  input  logic [PW_P-1:0] pc_in,
  output logic [PW_P-1:0] pc_out,
  output logic [PW_P-1:0] pc_oe,
  input  logic            hk_a_full,
  input  logic            hk_b_full
);
  localparam int HALF   = PW_P / 2;
  localparam int NLATCH = 2;

  cfg_t            cfg;
  logic            acc_wr, acc_rd, clr, inte_a, inte_b;
  logic            a_strobed, b_strobed;
  logic [PW_P-1:0] pc_lat, pc_view;
  logic [NLATCH-1:0][PW_P-1:0] lat_q;
  logic [NLATCH-1:0][PW_P-1:0] pin_v;
  logic [NLATCH-1:0]           lat_in;

  assign acc_wr    = cs & wr;
  assign acc_rd    = cs & rd;
  assign a_strobed = |cfg.a_mode;
  assign b_strobed = cfg.b_mode;

  tp_ctrl #(.PW_P(PW_P)) u_ctrl (
    .clk(clk), .rst(rst),
    .ctl_we(acc_wr && addr == OFS_CTL),
    .pc_we(acc_wr && addr == OFS_C),
    .wdata(wdata), .cfg(cfg), .pc_lat(pc_lat),
    .inte_a(inte_a), .inte_b(inte_b), .clr(clr)
  );

  assign lat_in = {cfg.b_in, cfg.a_in};
  assign pin_v  = {pb_in, pa_in};

  for (genvar g = 0; g < NLATCH; g++) begin : g_port
    tp_latch #(.PW_P(PW_P)) u_lat (
      .clk(clk), .rst(rst), .clr(clr),
      .we(acc_wr && addr == AW_P'(g)),
      .is_in(lat_in[g]), .d(wdata), .q(lat_q[g])
    );
  end

  assign pa_out = lat_q[0];
  assign pb_out = lat_q[1];
  assign pc_out = pc_lat;
  assign pa_oe  = {PW_P{~cfg.a_in}};
  assign pb_oe  = {PW_P{~cfg.b_in}};

  always_comb begin
    pc_oe = {{HALF{~cfg.chi_in}}, {HALF{~cfg.clo_in}}};
    if (a_strobed) pc_oe[5:3] = 3'b000;
    if (b_strobed) pc_oe[2:0] = 3'b000;
  end

  always_comb begin
    for (int i = 0; i < PW_P; i++) begin
      if (i >= HALF) pc_view[i] = cfg.chi_in ? pc_in[i] : pc_lat[i];
      else           pc_view[i] = cfg.clo_in ? pc_in[i] : pc_lat[i];
    end
    if (a_strobed) begin
      pc_view[5] = hk_a_full;
      pc_view[4] = inte_a;
      pc_view[3] = hk_a_full & inte_a;
    end
    if (b_strobed) begin
      pc_view[2] = inte_b;
      pc_view[1] = hk_b_full;
      pc_view[0] = hk_b_full & inte_b;
    end
  end

  tp_rdmux #(.PW_P(PW_P), .AW_P(AW_P)) u_rd (
    .clk(clk), .rst(rst), .rd_en(acc_rd), .sel(addr),
    .a_val(cfg.a_in ? pa_in : lat_q[0]),
    .b_val(cfg.b_in ? pb_in : lat_q[1]),
    .c_val(pc_view), .rdata(rdata)
  );

  assert_strobed_a_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    a_strobed |-> (pc_oe[5:3] == 3'b000));

  assert_strobed_b_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
    b_strobed |-> (pc_oe[2:0] == 3'b000));

  assert_nocs_no_reconfig_R2: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic hk_a_full = 0, hk_b_full = 0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tri_port_pio u_dut (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .hk_a_full(hk_a_full), .hk_b_full(hk_b_full)
  );

  // bench model of the requirements
  logic m_ain, m_bin, m_bmode, m_chin, m_clin, m_inta, m_intb;
  logic [1:0] m_amode;
  logic [7:0] m_la, m_lb, m_lc, m_rd;

  task automatic m_reset();
    m_ain = 1; m_bin = 1; m_bmode = 0; m_chin = 1; m_clin = 1;
    m_amode = 0; m_inta = 0; m_intb = 0;
    m_la = 0; m_lb = 0; m_lc = 0; m_rd = 0;
  endtask

  function automatic logic [7:0] m_pcoe();
    logic [7:0] o;
    o = {m_chin ? 4'h0 : 4'hF, m_clin ? 4'h0 : 4'hF};
    if (m_amode != 0) o[5:3] = 3'b000;
    if (m_bmode) o[2:0] = 3'b000;
    return o;
  endfunction

  function automatic logic [7:0] m_pcview();
    logic [7:0] v;
    for (int i = 0; i < 8; i++)
      v[i] = ((i >= 4) ? m_chin : m_clin) ? pc_in[i] : m_lc[i];
    if (m_amode != 0) begin
      v[5] = hk_a_full; v[4] = m_inta; v[3] = hk_a_full & m_inta;
    end
    if (m_bmode) begin
      v[2] = m_intb; v[1] = hk_b_full; v[0] = hk_b_full & m_intb;
    end
    return v;
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ain ? pa_in : m_la;
      2'd1: return m_bin ? pb_in : m_lb;
      2'd2: return m_pcview();
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] msk;
    case (a)
      2'd0: if (!m_ain) m_la = d;
      2'd1: if (!m_bin) m_lb = d;
      2'd2: begin
        msk = {m_chin ? 4'h0 : 4'hF, m_clin ? 4'h0 : 4'hF};
        m_lc = (m_lc & ~msk) | (d & msk);
      end
      default: begin
        if (d[7]) begin
          m_ain = d[4]; m_amode = d[6:5]; m_bin = d[1]; m_bmode = d[2];
          m_chin = d[3]; m_clin = d[0];
          m_la = 0; m_lb = 0; m_lc = 0; m_inta = 0; m_intb = 0;
        end else begin
          m_lc[d[3:1]] = d[0];
          if (d[3:1] == 3'd4) m_inta = d[0];
          if (d[3:1] == 3'd2) m_intb = d[0];
        end
      end
    endcase
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic chk_pins(input string tag);
    chk(tag, pa_oe, {8{~m_ain}});
    chk(tag, pb_oe, {8{~m_bin}});
    chk(tag, pc_oe, m_pcoe());
    chk(tag, pa_out, m_la);
    chk(tag, pb_out, m_lb);
    chk(tag, pc_out, m_lc);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk); cs = sel; addr = a; wdata = d; wr = 1;
    @(negedge clk); cs = 0; wr = 0;
    if (sel) m_write(a, d);
  endtask

  task automatic bus_rd(input logic [1:0] a, input bit sel, input string tag);
    @(negedge clk); cs = sel; addr = a; rd = 1;
    if (sel) m_rd = m_read(a);
    @(negedge clk); cs = 0; rd = 0;
    chk(tag, rdata, m_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_pins("R1");
    chk("R1", rdata, 8'h00);

    // R5 input read returns pins
    pa_in = 8'h5A;
    bus_rd(2'd0, 1, "R5");
    chk("R5", rdata, 8'h5A);

    // R3 mode word 0x90
    bus_wr(2'd3, 8'h90, 1);
    chk("R3", pa_oe, 8'h00);
    chk("R3", pb_oe, 8'hFF);
    chk("R3", pc_oe, 8'hFF);

    // R6 output drive and discarded input write
    bus_wr(2'd1, 8'h3C, 1);
    chk("R6", pb_out, 8'h3C);
    bus_wr(2'd0, 8'h77, 1);
    chk("R6", pa_out, 8'h00);
    bus_rd(2'd1, 1, "R11");
    chk("R11", rdata, 8'h3C);

    // R2 cs low ignored
    bus_wr(2'd3, 8'h9B, 0);
    chk("R2", pb_oe, 8'hFF);
    bus_wr(2'd1, 8'hC3, 0);
    chk("R2", pb_out, 8'h3C);
    pa_in = 8'h11;
    bus_rd(2'd0, 0, "R2");
    chk("R2", rdata, 8'h3C);

    // R7 bit set
    bus_wr(2'd3, 8'h09, 1);
    chk("R7", pc_out, 8'h10);
    chk("R7", pb_oe, 8'hFF);

    // R4 and R9 strobed A
    bus_wr(2'd3, 8'hB0, 1);
    chk("R4", pb_out, 8'h00);
    chk("R4", pc_out, 8'h00);
    chk("R9", pc_oe, 8'hC7);
    bus_wr(2'd3, 8'h09, 1);
    hk_a_full = 1;
    bus_rd(2'd2, 1, "R9");
    chk("R9", rdata, 8'h38);
    hk_a_full = 0;
    bus_rd(2'd2, 1, "R9");
    chk("R9", rdata, 8'h10);

    // R10 strobed B
    bus_wr(2'd3, 8'h86, 1);
    chk("R10", pc_oe, 8'hF8);
    bus_wr(2'd3, 8'h05, 1);
    hk_b_full = 1;
    bus_rd(2'd2, 1, "R10");
    chk("R10", rdata, 8'h07);
    hk_b_full = 0;

    // R11 control read, R8 port C input nibbles
    bus_rd(2'd3, 1, "R11");
    chk("R11", rdata, 8'h00);
    bus_wr(2'd3, 8'h89, 1);
    pc_in = 8'hA5;
    bus_rd(2'd2, 1, "R8");
    chk("R8", rdata, 8'hA5);
    bus_wr(2'd3, 8'h81, 1);
    bus_wr(2'd2, 8'h6E, 1);
    chk("R8", pc_out, 8'h60);
    bus_rd(2'd2, 1, "R8");

    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] d;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      hk_a_full = 1'($urandom); hk_b_full = 1'($urandom);
      op = int'($urandom_range(0, 9));
      d  = 8'($urandom);
      case (op)
        0, 1: begin bus_wr(2'd3, {1'b1, d[6:0]}, 1); chk_pins("R3"); end
        2, 3: begin bus_wr(2'd3, {1'b0, d[6:0]}, 1); chk_pins("R7"); end
        4:    begin bus_wr(2'd0, d, 1); chk_pins("R6"); end
        5:    begin bus_wr(2'd1, d, 1); chk_pins("R6"); end
        6:    begin bus_wr(2'd2, d, 1); chk_pins("R8"); end
        7:    bus_rd(2'd2, 1, "R8");
        8:    bus_rd(2'(d[1:0]), 1, "R5");
        default: begin bus_wr(2'(d[1:0]), d, 0); bus_rd(2'(d[3:2]), 0, "R2"); chk_pins("R2"); end
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule